// File: doc/BRIEF.md
# Piezo Buzzer Square-Wave Divider

This block produces a square wave for a piezoelectric sounder. A free-running prescaler counts the fast main clock. A second, short prescaler counts pulses of the slow sub clock. One of four prescaler rates is picked by a two-bit rate code held in an 8-bit control register. While the enable bit of that register is set, a toggle flip-flop turns the chosen rate into a waveform with an exact 50% duty cycle. While the enable bit is clear, the output pin simply carries the value of the general-purpose port latch.

A source input and an operating-mode input decide which prescaler supplies the taps. The fast taps are used only in normal operation with the source bit low. The slow taps are used when the source bit is high or when the chip runs in a low-speed or sleep mode. The rate code is protected against changes while the output runs. A write can change the code only while the output is already off. This rule also covers the write that turns the output off. The low five register bits belong to a neighbouring timer. They are stored and read back here but have no effect on this block.

The design uses a single clock. The sub clock arrives as a one-cycle enable pulse, `sub_tick`, and is not used as a clock.

Top module: `buzz_divout`

## Requirements
- R1: After reset the control register reads 0x00, the output is disabled, and `pin_out` equals `port_latch`.
- R2: A write while the enable bit (bit 7) reads 0 stores all eight bits of `wr_data`, and the new value is readable on `rd_data` in the cycle after the write edge.
- R3: The fast-clock taps are used only when `slow_mode` = 0 and `src_sub` = 0. In every other case the taps come from the count of `sub_tick` pulses, and the output changes only in a cycle after a `sub_tick` pulse.
- R4: With fast-clock taps, rate codes 0, 1, 2 and 3 (bits 6:5) give an output period of 8192, 4096, 2048 and 1024 clock cycles.
- R5: With sub-clock taps, rate codes 0, 1, 2 and 3 give an output period of 32, 16, 8 and 4 `sub_tick` pulses.
- R6: While enabled, the high phase of the output lasts exactly half the period. The output changes only at the edge that follows a prescaler toggle pulse.
- R7: While bit 7 reads 0, `pin_out` equals `port_latch` in the same cycle, and the generated waveform has no effect on the pin.
- R8: A write made while bit 7 reads 1 leaves the rate code unchanged, including a write that clears bit 7. Bits 7 and 4:0 are still written.
- R9: In the first cycle after the output becomes enabled, `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; also the fast prescaler input |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: bit 7 enable, bits 6:5 rate code, bits 4:0 neighbour timer bits |
| rd_data | output | 8 | Control register contents |
| src_sub | input | 1 | 1 selects the sub-clock taps in normal operation |
| slow_mode | input | 1 | 1 while the chip is in a low-speed or sleep mode; forces the sub-clock taps |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| port_latch | input | 1 | Port output latch; drives the pin while the output is disabled |
| pin_out | output | 1 | Sounder pin |

## Verification
A register write is visible on `rd_data` at the first sample after the capturing edge, and the enable takes effect at that same edge. For this reason the bench checks the register value and the low starting level (R9) at the negative edge that ends each write. The pin follows `port_latch` combinationally while disabled, so those checks sample one time step after the latch is driven. Period and duty results are due only after one complete cycle of the waveform. The monitor therefore ignores the partial phase before the first rising edge, measures each later rise-to-rise interval in counted clock cycles, and compares it with the expected period that the driver placed in the queue.

// File: rtl/buzz_div_pkg.sv
// Shared constants for the buzzer divider: the control register layout and
// the number of selectable taps. Assumes an 8-bit register with the enable
// in the top bit and the rate code directly below it.
package buzz_div_pkg;
    localparam int CTRL_W  = 8;
    localparam int EN_BIT  = 7;
    localparam int SEL_LSB = 5;
    localparam int SEL_W   = 2;
    localparam int N_TAPS  = 1 << SEL_W;
    localparam int LOW_W   = SEL_LSB;
endpackage

// File: rtl/buzz_ctrl_reg.sv
// Control register of the buzzer divider. It stores every bit on a write,
// except that the rate code is frozen while the enable bit currently reads 1.
// Assumes the write strobe lasts one cycle and lies in the clk domain.
module buzz_ctrl_reg
    import buzz_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              out_en,
    output logic [SEL_W-1:0]  rate_sel
);
    logic [CTRL_W-1:0] reg_q;

    // Purpose: register update with the rate-code write guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q[EN_BIT]      <= wr_data[EN_BIT];
            reg_q[LOW_W-1:0]   <= wr_data[LOW_W-1:0];
            if (!reg_q[EN_BIT]) begin
                reg_q[SEL_LSB +: SEL_W] <= wr_data[SEL_LSB +: SEL_W];
            end
        end
    end

    assign ctrl_q   = reg_q;
    assign out_en   = reg_q[EN_BIT];
    assign rate_sel = reg_q[SEL_LSB +: SEL_W];
endmodule

// File: rtl/buzz_prescaler.sv
// Two free-running prescalers: one counts clk, the other counts sub_tick
// pulses. For each rate code, a hit marks the cycle in which the output
// flip-flop must toggle, so the output period is 2^(EXP0-code) source
// ticks. Assumes MAIN_EXP0 and SUB_EXP0 are at least N_TAPS+1.
module buzz_prescaler
    import buzz_div_pkg::*;
#(
    parameter int MAIN_EXP0 = 13,
    parameter int SUB_EXP0  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_tick,
    input  logic             src_sub,
    input  logic             slow_mode,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tog_pulse
);
    localparam int MAIN_W = MAIN_EXP0 - 1;
    localparam int SUB_W  = SUB_EXP0 - 1;

    logic [MAIN_W-1:0] main_cnt;
    logic [SUB_W-1:0]  sub_cnt;
    logic [N_TAPS-1:0] main_hit;
    logic [N_TAPS-1:0] sub_hit;
    logic              use_sub;

    // Purpose: fast prescaler advancing every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) main_cnt <= '0;
        else        main_cnt <= main_cnt + 1'b1;
    end

    // Purpose: slow prescaler advancing on each sub-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        sub_cnt <= '0;
        else if (sub_tick) sub_cnt <= sub_cnt + 1'b1;
    end

    for (genvar c = 0; c < N_TAPS; c++) begin : g_tap
        localparam int MB = MAIN_EXP0 - 1 - c;
        localparam int SB = SUB_EXP0 - 1 - c;
        assign main_hit[c] = &main_cnt[MB-1:0];
        assign sub_hit[c]  = sub_tick & (&sub_cnt[SB-1:0]);
    end

    assign use_sub   = src_sub | slow_mode;
    assign tog_pulse = use_sub ? sub_hit[rate_sel] : main_hit[rate_sel];
endmodule

// File: rtl/buzz_wave.sv
// Output stage: a toggle flip-flop that is held at 0 while disabled, and a pin
// multiplexer that passes the port latch through while disabled.
// Assumes tog_pulse is a one-cycle strobe in the clk domain.
module buzz_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic tog_pulse,
    input  logic port_latch,
    output logic pin_out
);
    logic tog_q;

    // Purpose: toggle on each prescaler hit while enabled; otherwise hold low.
    always_ff @(posedge clk) begin
        if (!rst_n || !out_en) tog_q <= 1'b0;
        else if (tog_pulse)    tog_q <= ~tog_q;
    end

    assign pin_out = out_en ? tog_q : port_latch;
endmodule

// File: rtl/buzz_divout.sv
// Top of the buzzer divider output. It joins the control register, the
// prescalers and the output stage. Single clock; the sub clock enters as
// the sub_tick enable pulse.
module buzz_divout
    import buzz_div_pkg::*;
#(
    parameter int MAIN_EXP0 = 13,
    parameter int SUB_EXP0  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              src_sub,
    input  logic              slow_mode,
    input  logic              sub_tick,
    input  logic              port_latch,
    output logic              pin_out
);
    logic             out_en;
    logic [SEL_W-1:0] rate_sel;
    logic             tog_pulse;

    buzz_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ctrl_q   (rd_data),
        .out_en   (out_en),
        .rate_sel (rate_sel)
    );

    buzz_prescaler #(
        .MAIN_EXP0 (MAIN_EXP0),
        .SUB_EXP0  (SUB_EXP0)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .src_sub   (src_sub),
        .slow_mode (slow_mode),
        .rate_sel  (rate_sel),
        .tog_pulse (tog_pulse)
    );

    buzz_wave u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_en     (out_en),
        .tog_pulse  (tog_pulse),
        .port_latch (port_latch),
        .pin_out    (pin_out)
    );
endmodule

// File: rtl/buzz_divout_chk.sv
// Property checker for buzz_divout, attached with bind. It watches the
// ports and the prescaler toggle strobe.
module buzz_divout_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       src_sub,
    input logic       slow_mode,
    input logic       sub_tick,
    input logic       port_latch,
    input logic       pin_out,
    input logic       tog_pulse
);
    AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> rd_data == 8'h00); // R1
    AST_SUB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sub || slow_mode) && tog_pulse |-> sub_tick); // R3
    AST_PIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] && $past(rd_data[7]) && !$past(tog_pulse) |-> $stable(pin_out)); // R6
    AST_OFF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |-> pin_out == port_latch); // R7
    AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] && wr_en |=> rd_data[6:5] == $past(rd_data[6:5])); // R8
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[7]) |-> !pin_out); // R9
endmodule

bind buzz_divout buzz_divout_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .src_sub    (src_sub),
    .slow_mode  (slow_mode),
    .sub_tick   (sub_tick),
    .port_latch (port_latch),
    .pin_out    (pin_out),
    .tog_pulse  (tog_pulse)
);

// File: tb/buzz_divout_tb_top.sv
// Scoreboard bench: the driver queues expected periods and the monitor
// measures rise-to-rise intervals on the pin and compares them.
module buzz_divout_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       src_sub = 1'b0;
    logic       slow_mode = 1'b0;
    logic       sub_tick = 1'b0;
    logic       port_latch = 1'b0;
    logic       pin_out;

    typedef struct {
        int    period;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   arm = 1'b0;
    int   tick_div = 0;

    buzz_divout dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .src_sub    (src_sub),
        .slow_mode  (slow_mode),
        .sub_tick   (sub_tick),
        .port_latch (port_latch),
        .pin_out    (pin_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // sub_tick: one pulse every 4 clocks, driven away from the active edge
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        sub_tick = (tick_div == 0);
    end

    task automatic check(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic write_reg(logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Monitor: measures period and high phase after the first full rise
    int   last_rise = -1;
    int   last_fall = -1;
    logic prev_pin = 1'b0;
    always @(negedge clk) begin
        if (!arm) begin
            last_rise = -1;
            last_fall = -1;
        end else if (pin_out && !prev_pin) begin
            if (last_rise >= 0 && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(cyc - last_rise == e.period, e.tag, cyc - last_rise, e.period);
                check(last_fall - last_rise == e.period / 2, "R6 high phase",
                      last_fall - last_rise, e.period / 2);
            end
            last_rise = cyc;
        end else if (!pin_out && prev_pin) begin
            last_fall = cyc;
        end
        prev_pin = pin_out;
    end

    task automatic run_period(bit slow, bit src, int code, int expp, string tag, int n);
        @(negedge clk);
        slow_mode = slow;
        src_sub   = src;
        write_reg(8'h80 | 8'(code << 5));
        check(pin_out == 1'b0, "R9 starts low", int'(pin_out), 0);
        arm = 1'b1;
        repeat (n) sb_q.push_back('{expp, tag});
        wait (sb_q.size() == 0);
        @(negedge clk);
        arm = 1'b0;
        write_reg(8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        int hi_cnt;
        port_latch = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h00, "R1 reset value", int'(rd_data), 0);
        check(pin_out == 1'b1, "R1 pin follows latch", int'(pin_out), 1);

        // R7: latch passes through while disabled
        port_latch = 1'b0;
        #1 check(pin_out == 1'b0, "R7 latch low", int'(pin_out), 0);
        @(negedge clk);
        port_latch = 1'b1;
        #1 check(pin_out == 1'b1, "R7 latch high", int'(pin_out), 1);
        port_latch = 1'b0;
        hi_cnt = 0;
        repeat (3000) begin
            @(negedge clk);
            if (pin_out) hi_cnt++;
        end
        check(hi_cnt == 0, "R7 no waveform while off", hi_cnt, 0);

        // R2: full write while disabled
        write_reg(8'h5A);
        check(rd_data == 8'h5A, "R2 readback", int'(rd_data), 'h5A);
        write_reg(8'h00);

        // R4: fast taps
        for (int c = 0; c < 4; c++)
            run_period(1'b0, 1'b0, c, 1 << (13 - c), "R4 main period", 2);
        // R3 R5: every route to the sub-clock taps (sub_tick every 4 clocks)
        for (int m = 1; m < 4; m++)
            for (int c = 0; c < 4; c++)
                run_period(m[1], m[0], c, 4 * (1 << (5 - c)), "R3 R5 sub period", 2);

        // R8: rate code frozen while enabled
        slow_mode = 1'b0;
        src_sub   = 1'b0;
        write_reg(8'hE0);
        write_reg(8'h81);
        check(rd_data == 8'hE1, "R8 code kept, low bits written", int'(rd_data), 'hE1);
        arm = 1'b1;
        sb_q.push_back('{1024, "R8 period unchanged"});
        wait (sb_q.size() == 0);
        @(negedge clk);
        arm = 1'b0;
        write_reg(8'h00);
        check(rd_data == 8'h60, "R8 clearing write keeps code", int'(rd_data), 'h60);
        write_reg(8'h1F);
        check(rd_data == 8'h1F, "R2 code written while off", int'(rd_data), 'h1F);
        port_latch = 1'b1;
        #1 check(pin_out == 1'b1, "R7 latch after disable", int'(pin_out), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule